// File: doc/BRIEF.md
# Two-Wire Nonvolatile Memory Write Slave

This block is the write-side front end of a byte-addressed nonvolatile memory that sits on a two-wire serial bus (I2C-style, open-drain SDA, master-driven SCL). It oversamples both bus lines with the system clock and finds start and stop conditions. It checks the device-type field of the first byte and then collects a two-byte word address. Every data byte that follows is handed to a downstream page latch as a one-cycle strobe, together with its data and its target byte address.

The address used for successive data bytes advances inside one page only. The low page-offset bits wrap at the page end and the page-select bits stay fixed, so a long burst overwrites earlier bytes of the same page. A stop condition that ends a transfer carrying at least one data byte raises a one-cycle commit request. From then on the slave is deaf to the bus and keeps SDA released until the downstream busy flag drops.

Top module: `eewr_slave`

## Requirements
- R1: A falling SDA edge while SCL is high is a start condition and a rising SDA edge while SCL is high is a stop condition. Data bits are sampled on rising SCL, most significant bit first.
- R2: The first byte after a start is acknowledged only when its bits [7:4] equal 4'b1010 and its bit 0 is 0. Bits [3:1] are ignored.
- R3: A first byte that does not match, including one with bit 0 set (a read), gets no acknowledge and produces no strobe or commit. The slave ignores the rest of that transfer until the next start.
- R4: The slave acknowledges by driving SDA low (sda_oe_o = 1) from the SCL fall after a byte's eighth bit until the SCL fall that ends the ninth clock. It never begins to drive while SCL is high.
- R5: The two bytes after the first byte are both acknowledged. They form a 16-bit word address, high byte first, and only its low ADDR_W bits (12 by default) are kept.
- R6: Every data byte is acknowledged and produces a one-cycle wr_valid_o pulse carrying the byte on wr_data_o and its target address on wr_addr_o.
- R7: After each data byte, the low PAGE_W bits of the address (5 by default, a 32-byte page) increment modulo the page size while the upper bits stay unchanged. 0x41E is followed by 0x41F, 0x400 and 0x401.
- R8: A stop after at least one data byte raises commit_o for exactly one cycle. A stop before any data byte raises no commit.
- R9: From the commit until busy_i is low again, the slave does not acknowledge, strobe or commit, even for a matching first byte, and keeps sda_oe_o at 0.
- R10: A start in the middle of a byte aborts the transfer without a commit or a strobe for the partial byte, and address reception restarts at the first byte.
- R11: Out of reset, sda_oe_o, wr_valid_o and commit_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad (wired value) |
| busy_i | input | 1 | Downstream internal write cycle in progress |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | ADDR_W | Byte address of the strobed data |
| wr_data_o | output | 8 | Strobed data byte |
| commit_o | output | 1 | One-cycle request to start the internal write cycle |

## Verification
The bench builds the block with its defaults: a 12-bit address and a 5-bit page offset on a 32-byte page. With these values the word addresses 0x000 and 0xFFF lie at the edges of the array, and a high address byte of 0xF3 shows its upper bits being dropped. A burst starting at offset 0x1E crosses the page end after two bytes, so the wrap back to offset 0 is seen within a four-byte page write. The downstream busy period is modelled at 500 cycles, which is longer than a full start plus address byte at the bench's bus rate, so a matching address can be sent entirely inside the deaf window.

// File: rtl/eewr_pkg.sv
// Package: shared constants and the transaction state type of the
// two-wire write slave. Assumes an 8-bit serial byte.
package eewr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start condition
        ST_DEV,    // receiving the device-select byte
        ST_WHI,    // receiving the high word-address byte
        ST_WLO,    // receiving the low word-address byte
        ST_DATA,   // receiving data bytes
        ST_HOLD    // deaf while the internal write cycle runs
    } eewr_state_e;

endpackage

// File: rtl/eewr_line_sync.sv
// Module: multi-bit line synchronizer with edge detection.
// Each input bit passes through STAGES flops; a further flop gives the
// previous synchronized value for rise/fall pulses. Assumes the lines
// idle high, so all flops reset to 1 and no edge is seen at reset.
module eewr_line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_line
            logic [STAGES-1:0] chain;
            logic              prev;

            // Shift the raw line through the sync chain and keep one older copy.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '1;
                    prev  <= 1'b1;
                end else begin
                    chain <= {chain[STAGES-2:0], din[i]};
                    prev  <= chain[STAGES-1];
                end
            end

            assign level[i] = chain[STAGES-1];
            assign rise[i]  = chain[STAGES-1] & ~prev;
            assign fall[i]  = ~chain[STAGES-1] & prev;
        end
    endgenerate

endmodule

// File: rtl/eewr_byte_shifter.sv
// Module: serial byte receiver with acknowledge driver.
// Shifts BITS data bits in on SCL rising edges (MSB first), pulses
// byte_done for one cycle after the last bit, and, when ack_want is high
// in that pulse cycle, pulls SDA low from the next SCL fall until the SCL
// fall after the acknowledge clock. Assumes clr on start, stop or deafness.
module eewr_byte_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            sda_bit,
    input  logic            ack_want,
    output logic [BITS-1:0] byte_o,
    output logic            byte_done,
    output logic            sda_oe
);

    localparam int             CW       = $clog2(BITS + 1);
    localparam logic [CW-1:0]  ACK_SLOT = CW'(BITS);
    localparam logic [CW-1:0]  LAST_BIT = CW'(BITS - 1);

    logic [CW-1:0] cnt;
    logic          ack_pend;

    // Count bits, shift data, and sequence the acknowledge drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            byte_o    <= '0;
            byte_done <= 1'b0;
            ack_pend  <= 1'b0;
            sda_oe    <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (clr) begin
                cnt      <= '0;
                ack_pend <= 1'b0;
                sda_oe   <= 1'b0;
            end else begin
                if (scl_rise) begin
                    if (cnt == ACK_SLOT) begin
                        cnt <= '0;
                    end else begin
                        byte_o <= {byte_o[BITS-2:0], sda_bit};
                        cnt    <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            byte_done <= 1'b1;
                        end
                    end
                end
                if (scl_fall) begin
                    if (cnt == ACK_SLOT && ack_pend) begin
                        sda_oe   <= 1'b1;
                        ack_pend <= 1'b0;
                    end else if (cnt == '0 && sda_oe) begin
                        sda_oe <= 1'b0;
                    end
                end
                if (byte_done && ack_want) begin
                    ack_pend <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/eewr_page_ctr.sv
// Module: byte address counter with in-page wrap.
// load sets the address; step increments only the low PAGE_W bits,
// wrapping at the page end, while the page-select bits are held.
// Assumes PAGE_W >= 1; a page as wide as the address wraps the whole array.
module eewr_page_ctr #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    generate
        if (PAGE_W >= ADDR_W) begin : g_flat
            // Whole address wraps as one page.
            always_ff @(posedge clk) begin
                if (!rst_n)    addr <= '0;
                else if (load) addr <= load_val;
                else if (step) addr <= addr + 1'b1;
            end
        end else begin : g_paged
            logic [PAGE_W-1:0] offs_next;
            assign offs_next = addr[PAGE_W-1:0] + 1'b1;

            // Page bits held, offset bits wrap on step.
            always_ff @(posedge clk) begin
                if (!rst_n)    addr <= '0;
                else if (load) addr <= load_val;
                else if (step) addr <= {addr[ADDR_W-1:PAGE_W], offs_next};
            end
        end
    endgenerate

endmodule

// File: rtl/eewr_slave.sv
// Module: two-wire nonvolatile-memory write slave (top).
// Detects start/stop, matches the device-type field, collects a two-byte
// word address, strobes each data byte with its in-page address to a
// downstream latch, and requests a commit on stop. Deaf with SDA released
// from the commit until busy_i falls. Assumes clk is well above the
// bus bit rate so each bus phase spans several clocks.
module eewr_slave #(
    parameter int         ADDR_W   = 12,
    parameter int         PAGE_W   = 5,
    parameter logic [3:0] DEV_TYPE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              busy_i,
    output logic              sda_oe_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              commit_o
);

    import eewr_pkg::*;

    localparam int WA_W = 2 * BYTE_W;

    logic [1:0]        ln_level, ln_rise, ln_fall;
    logic              scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;
    logic              start_ev, stop_ev, deaf, shift_clr;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_done, byte_ok, ack_want, dev_match;
    logic [BYTE_W-1:0] addr_hi;
    logic [WA_W-1:0]   word_addr;
    logic              ctr_load, ctr_step, got_data;
    logic [ADDR_W-1:0] cur_addr;
    eewr_state_e       state;

    eewr_line_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sda_i, scl_i}),
        .level (ln_level),
        .rise  (ln_rise),
        .fall  (ln_fall)
    );

    assign scl_lvl  = ln_level[0];
    assign scl_rise = ln_rise[0];
    assign scl_fall = ln_fall[0];
    assign sda_lvl  = ln_level[1];
    assign sda_rise = ln_rise[1];
    assign sda_fall = ln_fall[1];

    assign deaf      = (state == ST_HOLD) || busy_i;
    assign start_ev  = scl_lvl && sda_fall && !deaf;
    assign stop_ev   = scl_lvl && sda_rise && !deaf;
    assign shift_clr = start_ev || stop_ev || deaf;

    eewr_byte_shifter #(.BITS(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (shift_clr),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_bit   (sda_lvl),
        .ack_want  (ack_want),
        .byte_o    (rx_byte),
        .byte_done (rx_done),
        .sda_oe    (sda_oe_o)
    );

    assign byte_ok   = rx_done && !shift_clr;
    assign dev_match = (rx_byte[7:4] == DEV_TYPE) && !rx_byte[0];
    assign word_addr = {addr_hi, rx_byte};
    assign ctr_load  = byte_ok && (state == ST_WLO);
    assign ctr_step  = byte_ok && (state == ST_DATA);

    // Decide whether the byte just received earns an acknowledge.
    always_comb begin
        unique case (state)
            ST_DEV:                 ack_want = dev_match;
            ST_WHI, ST_WLO, ST_DATA: ack_want = 1'b1;
            default:                ack_want = 1'b0;
        endcase
    end

    eewr_page_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (word_addr[ADDR_W-1:0]),
        .step     (ctr_step),
        .addr     (cur_addr)
    );

    // Transaction sequencing, data strobes and commit request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            addr_hi    <= '0;
            got_data   <= 1'b0;
            wr_valid_o <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
            commit_o   <= 1'b0;
        end else begin
            wr_valid_o <= 1'b0;
            commit_o   <= 1'b0;
            if (deaf) begin
                got_data <= 1'b0;
                if (state != ST_HOLD || (!busy_i && !commit_o)) begin
                    state <= ST_IDLE;
                end
            end else if (start_ev) begin
                state    <= ST_DEV;
                got_data <= 1'b0;
            end else if (stop_ev) begin
                if (state == ST_DATA && got_data) begin
                    commit_o <= 1'b1;
                    state    <= ST_HOLD;
                end else begin
                    state <= ST_IDLE;
                end
                got_data <= 1'b0;
            end else if (byte_ok) begin
                unique case (state)
                    ST_DEV:  state <= dev_match ? ST_WHI : ST_IDLE;
                    ST_WHI: begin
                        addr_hi <= rx_byte;
                        state   <= ST_WLO;
                    end
                    ST_WLO:  state <= ST_DATA;
                    ST_DATA: begin
                        wr_valid_o <= 1'b1;
                        wr_addr_o  <= cur_addr;
                        wr_data_o  <= rx_byte;
                        got_data   <= 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/eewr_slave_chk.sv
// Module: assertion checker for eewr_slave, attached by bind.
// Tracks the address of the previous strobe inside one transfer to
// check the in-page increment. Assumes synchronous active-low reset.
module eewr_slave_chk #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              start_ev,
    input logic              busy_i,
    input logic              sda_oe_o,
    input logic              wr_valid_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic              commit_o
);

    localparam logic [ADDR_W-1:0] OFFS_MASK =
        (PAGE_W >= ADDR_W) ? '1 : ADDR_W'((64'd1 << PAGE_W) - 64'd1);

    logic [ADDR_W-1:0] prev_addr;
    logic              have_prev;

    // Remember the previous strobe address within the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr <= '0;
            have_prev <= 1'b0;
        end else if (start_ev) begin
            have_prev <= 1'b0;
        end else if (wr_valid_o) begin
            prev_addr <= wr_addr_o;
            have_prev <= 1'b1;
        end
    end

    // R4: acknowledge drive only ever begins while SCL is low.
    a_r4_ack_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_lvl);

    // R6: the data strobe lasts one cycle.
    a_r6_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);

    // R7: consecutive strobes keep the page and step the offset with wrap.
    a_r7_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && have_prev) |->
            (((wr_addr_o & ~OFFS_MASK) == (prev_addr & ~OFFS_MASK)) &&
             ((wr_addr_o & OFFS_MASK) == ((prev_addr + 1'b1) & OFFS_MASK))));

    // R8: commit request is a single-cycle pulse.
    a_r8_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    // R9: while busy, no drive, no strobe and no commit follow.
    a_r9_deaf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> (!sda_oe_o && !wr_valid_o && !commit_o));

endmodule

bind eewr_slave eewr_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl    (scl_lvl),
    .start_ev   (start_ev),
    .busy_i     (busy_i),
    .sda_oe_o   (sda_oe_o),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .commit_o   (commit_o)
);

// File: tb/eewr_slave_test.sv
// Bench: bus-master model plus downstream busy model for eewr_slave.
// A vector table of single-byte writes is walked first, then directed
// tests cover reset, page wrap, empty stop, deafness and abort.
module eewr_slave_test;

    localparam int ADDR_W = 12;
    localparam int QC     = 6;     // clocks per quarter bit
    localparam int BUSY   = 500;   // modelled internal write cycle

    // {expect_ack, dev, addr_hi, addr_lo, data, expected_addr}
    localparam int VW = 45;
    localparam int NV = 6;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 8'hA0, 8'h00, 8'h00, 8'h5A, 12'h000},
        {1'b1, 8'hAE, 8'h0F, 8'hFF, 8'hC3, 12'hFFF},
        {1'b1, 8'hA0, 8'hF3, 8'h21, 8'h77, 12'h321},
        {1'b0, 8'hB0, 8'h00, 8'h00, 8'h00, 12'h000},
        {1'b0, 8'hA1, 8'h00, 8'h00, 8'h00, 12'h000},
        {1'b0, 8'h20, 8'h00, 8'h00, 8'h00, 12'h000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl_m = 1'b1;
    logic              sda_m = 1'b1;
    logic              sda_bus;
    logic              busy_i = 1'b0;
    logic              sda_oe_o, wr_valid_o, commit_o;
    logic [ADDR_W-1:0] wr_addr_o;
    logic [7:0]        wr_data_o;

    int                n_vec = 0;
    int                n_bad = 0;
    int                busy_cnt = 0;
    int                wcnt = 0;
    int                ccnt = 0;
    logic [ADDR_W-1:0] wlog_addr [64];
    logic [7:0]        wlog_data [64];
    bit                done = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe_o;

    eewr_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .busy_i     (busy_i),
        .sda_oe_o   (sda_oe_o),
        .wr_valid_o (wr_valid_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .commit_o   (commit_o)
    );

    // Downstream model: log strobes, count commits, run the busy period.
    always @(negedge clk) begin
        if (wr_valid_o) begin
            if (wcnt < 64) begin
                wlog_addr[wcnt] = wr_addr_o;
                wlog_data[wcnt] = wr_data_o;
            end
            wcnt = wcnt + 1;
        end
        if (commit_o) begin
            ccnt     = ccnt + 1;
            busy_cnt = BUSY;
        end else if (busy_cnt > 0) begin
            busy_cnt = busy_cnt - 1;
        end
        busy_i = (busy_cnt != 0);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(QC);
        scl_m = 1'b1; tick(QC);
        sda_m = 1'b0; tick(QC);
        scl_m = 1'b0; tick(QC);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(QC);
        scl_m = 1'b1; tick(QC);
        sda_m = 1'b1; tick(QC);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    tick(QC);
        scl_m = 1'b1; tick(2 * QC);
        scl_m = 1'b0; tick(QC);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(QC);
        scl_m = 1'b1; tick(QC);
        ack = (sda_bus == 1'b0);
        tick(QC);
        scl_m = 1'b0; tick(QC);
    endtask

    task automatic wait_idle();
        tick(10);
        while (busy_i) tick(1);
        tick(10);
    endtask

    initial begin
        logic ack;
        int   w0, c0;

        // R11: reset state
        tick(4);
        check("R11 sda_oe", sda_oe_o, 0);
        check("R11 wr_valid", wr_valid_o, 0);
        check("R11 commit", commit_o, 0);
        rst_n = 1'b1;
        tick(10);

        // Vector table: single-byte writes and rejected first bytes
        for (int v = 0; v < NV; v++) begin
            w0 = wcnt; c0 = ccnt;
            bus_start();
            send_byte(VEC[v][43:36], ack);
            check(VEC[v][44] ? "R2 dev ack" : "R3 dev nack", ack, VEC[v][44]);
            if (VEC[v][44]) begin
                send_byte(VEC[v][35:28], ack); check("R5 hi ack", ack, 1);
                send_byte(VEC[v][27:20], ack); check("R5 lo ack", ack, 1);
                send_byte(VEC[v][19:12], ack); check("R6 data ack", ack, 1);
                bus_stop();
                tick(10);
                check("R6 strobe count", wcnt - w0, 1);
                check("R5 addr", wlog_addr[w0], VEC[v][11:0]);
                check("R1 data", wlog_data[w0], VEC[v][19:12]);
                check("R8 commit", ccnt - c0, 1);
            end else begin
                send_byte(8'h00, ack); check("R3 ignored", ack, 0);
                bus_stop();
                tick(10);
                check("R3 no strobe", wcnt - w0, 0);
                check("R3 no commit", ccnt - c0, 0);
            end
            wait_idle();
        end

        // R7: page write crossing the page end
        w0 = wcnt; c0 = ccnt;
        bus_start();
        send_byte(8'hA0, ack); check("R2 ack", ack, 1);
        send_byte(8'h04, ack);
        send_byte(8'h1E, ack);
        send_byte(8'h11, ack); check("R6 ack 0", ack, 1);
        send_byte(8'h22, ack); check("R6 ack 1", ack, 1);
        send_byte(8'h33, ack); check("R6 ack 2", ack, 1);
        send_byte(8'h44, ack); check("R6 ack 3", ack, 1);
        bus_stop();
        tick(10);
        check("R6 page count", wcnt - w0, 4);
        check("R7 addr 0", wlog_addr[w0],     12'h41E);
        check("R7 addr 1", wlog_addr[w0 + 1], 12'h41F);
        check("R7 addr 2", wlog_addr[w0 + 2], 12'h400);
        check("R7 addr 3", wlog_addr[w0 + 3], 12'h401);
        check("R6 data 2", wlog_data[w0 + 2], 8'h33);
        check("R8 one commit", ccnt - c0, 1);

        // R9: matching address during busy gets no ack
        bus_start();
        send_byte(8'hA0, ack);
        check("R9 busy during test", busy_i, 1);
        check("R9 no ack", ack, 0);
        send_byte(8'h00, ack); check("R9 no ack hi", ack, 0);
        bus_stop();
        tick(10);
        check("R9 no extra commit", ccnt - c0, 1);
        check("R9 no strobe", wcnt - w0, 4);
        wait_idle();

        // R8: stop before any data gives no commit
        w0 = wcnt; c0 = ccnt;
        bus_start();
        send_byte(8'hA0, ack); check("R2 ack", ack, 1);
        send_byte(8'h01, ack); check("R5 ack", ack, 1);
        send_byte(8'h23, ack); check("R5 ack", ack, 1);
        bus_stop();
        tick(20);
        check("R8 no commit", ccnt - c0, 0);
        check("R8 no strobe", wcnt - w0, 0);

        // R10: start mid-byte aborts, then a fresh transfer completes
        w0 = wcnt; c0 = ccnt;
        bus_start();
        send_byte(8'hA0, ack);
        send_byte(8'h01, ack);
        send_byte(8'h00, ack);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        tick(10);
        check("R10 no commit on abort", ccnt - c0, 0);
        send_byte(8'hA0, ack); check("R10 restart ack", ack, 1);
        send_byte(8'h02, ack);
        send_byte(8'h05, ack);
        send_byte(8'h99, ack);
        bus_stop();
        tick(10);
        check("R10 strobe count", wcnt - w0, 1);
        check("R10 addr", wlog_addr[w0], 12'h205);
        check("R10 data", wlog_data[w0], 8'h99);
        check("R10 commit", ccnt - c0, 1);
        wait_idle();
        check("R4 released", sda_oe_o, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule